// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block freezes the running 64-bit time value at the moment a packet on the receive path or the transmit path is marked for timestamping. Each direction has its own one-deep latch. When that direction's event strobe arrives while capture is enabled and the latch is empty, the block stores the time, raises a valid flag and steps a small capture sequence count. The stored value then stays put, and later strobes have no effect, until software re-arms the latch by writing a one to the valid flag's bit position.

Software reads one 32-bit status word and two 32-bit timestamp halves per direction. A cleared valid flag means the held halves must not be trusted. Any change to a direction's 3-bit enable field counts as a reconfiguration, and it discards a stale capture.

Top module: `pkt_ts_latch`

## Requirements
- R1: After reset, both status words and all four timestamp halves read zero.
- R2: An event strobe accepted at a clock edge makes that direction's status bit 16 (valid) read 1 after that edge. The same edge loads the low half with time bits [31:0] and the high half with time bits [63:32], both sampled at that edge. A strobe is accepted when the enable is non-zero, valid is 0, and there is neither a re-arm nor an enable change in that cycle.
- R3: While valid is 1, event strobes are ignored: status and both halves keep their values.
- R4: A status write whose data bit 16 is 1 clears valid at the next edge and leaves the held halves and the sequence count unchanged. A status write whose data bit 16 is 0 has no effect.
- R5: When a re-arm write and an event strobe arrive in the same cycle, the re-arm wins. Valid ends at 0, the halves are unchanged and the sequence count does not step.
- R6: An enable value of 0 blocks capture for that direction.
- R7: Any change of a direction's enable value clears that direction's valid flag at the next edge, and any event strobe in that cycle is dropped.
- R8: Status bits [15:0] hold a count that increments by one on each accepted capture. Status bits [31:17] read 0.
- R9: The receive and transmit latches are independent. An event, write or enable change on one direction leaves the other direction's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Current time counter value |
| rxEvent | input | 1 | Receive timestamp event strobe |
| txEvent | input | 1 | Transmit timestamp event strobe |
| rxEnable | input | 3 | Receive capture enable field; 0 disables |
| txEnable | input | 3 | Transmit capture enable field; 0 disables |
| rxStatusWr | input | 1 | Write strobe for the receive status word |
| rxStatusWrData | input | 32 | Receive status write data; bit 16 re-arms |
| txStatusWr | input | 1 | Write strobe for the transmit status word |
| txStatusWrData | input | 32 | Transmit status write data; bit 16 re-arms |
| rxStatus | output | 32 | Receive status: bit 16 valid, [15:0] count |
| rxTsLow | output | 32 | Receive captured time bits [31:0] |
| rxTsHigh | output | 32 | Receive captured time bits [63:32] |
| txStatus | output | 32 | Transmit status: bit 16 valid, [15:0] count |
| txTsLow | output | 32 | Transmit captured time bits [31:0] |
| txTsHigh | output | 32 | Transmit captured time bits [63:32] |

## Verification
A stuck or wrongly set valid flag shows one cycle after the stimulus that should have changed it. The status word then reads the wrong bit 16, and the next event either fails to land or overwrites a held value. A sequence count that steps on a dropped event, or a halves register that reloads while valid is set, appears in the very next status or timestamp read. Crosstalk between the directions shows on the idle direction's outputs in the cycle after the other direction's stimulus.

// File: rtl/pkt_ts_pkg.sv
package pkt_ts_pkg;
  parameter int unsigned VALID_BIT = 16;

  typedef struct packed {
    logic capture;
    logic clear;
  } latch_ctrl_t;
endpackage

// File: rtl/ts_latch_ctrl.sv
module ts_latch_ctrl
  import pkt_ts_pkg::*;
#(
  parameter int unsigned EN_W = 3,
  parameter int unsigned WD_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtIn,
  input  logic [EN_W-1:0] enable,
  input  logic            statusWr,
  input  logic [WD_W-1:0] statusWrData,
  output latch_ctrl_t     ctrl,
  output logic            valid
);
  logic [EN_W-1:0] prevEn;
  logic            enChanged;
  logic            rearm;

  assign enChanged    = (prevEn != enable);
  assign rearm        = statusWr && statusWrData[VALID_BIT];
  assign ctrl.clear   = rearm || enChanged;
  assign ctrl.capture = evtIn && (enable != '0) && !valid && !ctrl.clear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid  <= 1'b0;
      prevEn <= '0;
    end else begin
      prevEn <= enable;
      if (ctrl.clear)        valid <= 1'b0;
      else if (ctrl.capture) valid <= 1'b1;
    end
  end

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> valid); // R2
  AST_HOLD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !statusWr && $stable(enable)) |=> valid); // R3
  AST_REARM_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && statusWrData[VALID_BIT] && evtIn) |=> !valid); // R5
  AST_DISABLED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (enable == '0) |-> !ctrl.capture); // R6
  AST_ENABLE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (prevEn != enable) |=> !valid); // R7
endmodule

// File: rtl/ts_latch_data.sv
module ts_latch_data
  import pkt_ts_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  latch_ctrl_t       ctrl,
  input  logic [TIME_W-1:0] timeNow,
  output logic [TIME_W-1:0] tsHeld,
  output logic [SEQ_W-1:0]  seqCount
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsHeld   <= '0;
      seqCount <= '0;
    end else if (ctrl.capture) begin
      tsHeld   <= timeNow;
      seqCount <= seqCount + 1'b1;
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (seqCount == $past(seqCount) + 1'b1)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(tsHeld) && $stable(seqCount))); // R3
endmodule

// File: rtl/pkt_ts_latch.sv
module pkt_ts_latch
  import pkt_ts_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned EN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              rxEvent,
  input  logic              txEvent,
  input  logic [EN_W-1:0]   rxEnable,
  input  logic [EN_W-1:0]   txEnable,
  input  logic              rxStatusWr,
  input  logic [HALF_W-1:0] rxStatusWrData,
  input  logic              txStatusWr,
  input  logic [HALF_W-1:0] txStatusWrData,
  output logic [HALF_W-1:0] rxStatus,
  output logic [HALF_W-1:0] rxTsLow,
  output logic [HALF_W-1:0] rxTsHigh,
  output logic [HALF_W-1:0] txStatus,
  output logic [HALF_W-1:0] txTsLow,
  output logic [HALF_W-1:0] txTsHigh
);
  localparam int unsigned NUM_DIR = 2;

  logic [NUM_DIR-1:0]             evtArr;
  logic [NUM_DIR-1:0][EN_W-1:0]   enArr;
  logic [NUM_DIR-1:0]             wrArr;
  logic [NUM_DIR-1:0][HALF_W-1:0] wrDataArr;
  logic [NUM_DIR-1:0][HALF_W-1:0] statArr;
  logic [NUM_DIR-1:0][TIME_W-1:0] tsArr;

  assign evtArr    = {txEvent, rxEvent};
  assign enArr     = {txEnable, rxEnable};
  assign wrArr     = {txStatusWr, rxStatusWr};
  assign wrDataArr = {txStatusWrData, rxStatusWrData};

  for (genvar d = 0; d < NUM_DIR; d++) begin : gDir
    latch_ctrl_t      ctrl;
    logic             valid;
    logic [SEQ_W-1:0] seq;

    ts_latch_ctrl #(.EN_W(EN_W), .WD_W(HALF_W)) uCtrl (
      .clk(clk), .rstN(rstN), .evtIn(evtArr[d]), .enable(enArr[d]),
      .statusWr(wrArr[d]), .statusWrData(wrDataArr[d]),
      .ctrl(ctrl), .valid(valid)
    );

    ts_latch_data #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) uData (
      .clk(clk), .rstN(rstN), .ctrl(ctrl), .timeNow(timeNow),
      .tsHeld(tsArr[d]), .seqCount(seq)
    );

    always_comb begin
      statArr[d]              = '0;
      statArr[d][SEQ_W-1:0]   = seq;
      statArr[d][VALID_BIT]   = valid;
    end
  end

  assign rxStatus = statArr[0];
  assign txStatus = statArr[1];
  assign rxTsLow  = tsArr[0][HALF_W-1:0];
  assign rxTsHigh = tsArr[0][TIME_W-1:HALF_W];
  assign txTsLow  = tsArr[1][HALF_W-1:0];
  assign txTsHigh = tsArr[1][TIME_W-1:HALF_W];
endmodule

// File: tb/pkt_ts_latch_test.sv
`timescale 1ns/1ps
module pkt_ts_latch_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] timeNow;
  logic        rxEvent, txEvent;
  logic [2:0]  rxEnable, txEnable;
  logic        rxStatusWr, txStatusWr;
  logic [31:0] rxStatusWrData, txStatusWrData;
  logic [31:0] rxStatus, rxTsLow, rxTsHigh, txStatus, txTsLow, txTsHigh;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pkt_ts_latch uut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow),
    .rxEvent(rxEvent), .txEvent(txEvent),
    .rxEnable(rxEnable), .txEnable(txEnable),
    .rxStatusWr(rxStatusWr), .rxStatusWrData(rxStatusWrData),
    .txStatusWr(txStatusWr), .txStatusWrData(txStatusWrData),
    .rxStatus(rxStatus), .rxTsLow(rxTsLow), .rxTsHigh(rxTsHigh),
    .txStatus(txStatus), .txTsLow(txTsLow), .txTsHigh(txTsHigh)
  );

  always #2.5 clk = ~clk;

  localparam logic [31:0] VBIT = 32'h0001_0000;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic checkRx(input string tag, input logic [31:0] st, input logic [63:0] ts);
    check({tag, " rxStatus"}, {32'h0, rxStatus}, {32'h0, st});
    check({tag, " rxTs"}, {rxTsHigh, rxTsLow}, ts);
  endtask

  task automatic checkTx(input string tag, input logic [31:0] st, input logic [63:0] ts);
    check({tag, " txStatus"}, {32'h0, txStatus}, {32'h0, st});
    check({tag, " txTs"}, {txTsHigh, txTsLow}, ts);
  endtask

  task automatic pulseRx(input logic [63:0] t);
    timeNow = t; rxEvent = 1'b1; cyc(); rxEvent = 1'b0;
  endtask

  task automatic pulseTx(input logic [63:0] t);
    timeNow = t; txEvent = 1'b1; cyc(); txEvent = 1'b0;
  endtask

  task automatic writeRx(input logic [31:0] d);
    rxStatusWr = 1'b1; rxStatusWrData = d; cyc(); rxStatusWr = 1'b0; rxStatusWrData = '0;
  endtask

  localparam logic [63:0] TA = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] TB = 64'hFFFF_0000_AAAA_5555;
  localparam logic [63:0] TC = 64'h0000_0001_0000_0002;
  localparam logic [63:0] TD = 64'hDEAD_BEEF_CAFE_F00D;
  localparam logic [63:0] TE = 64'h0F0F_0F0F_F0F0_F0F0;
  localparam logic [63:0] TF = 64'h8000_0000_0000_0001;

  task automatic testReset();
    rstN = 1'b0; timeNow = TA; rxEvent = 0; txEvent = 0;
    rxEnable = 0; txEnable = 0; rxStatusWr = 0; txStatusWr = 0;
    rxStatusWrData = 0; txStatusWrData = 0;
    repeat (3) cyc();
    rstN = 1'b1; cyc();
    checkRx("R1 reset", 32'h0, 64'h0);
    checkTx("R1 reset", 32'h0, 64'h0);
  endtask

  task automatic testCapture();
    rxEnable = 3'd7; txEnable = 3'd5; cyc(); cyc();
    pulseRx(TA);
    checkRx("R2 capture", VBIT | 32'd1, TA);
    checkTx("R9 tx untouched by rx", 32'h0, 64'h0);
  endtask

  task automatic testHold();
    pulseRx(TB);
    checkRx("R3 hold", VBIT | 32'd1, TA);
  endtask

  task automatic testRearm();
    writeRx(32'hFFFE_FFFF);
    checkRx("R4 write bit16=0 ignored", VBIT | 32'd1, TA);
    writeRx(VBIT);
    checkRx("R4 rearm clears", 32'd1, TA);
    pulseRx(TC);
    checkRx("R8 second capture counts", VBIT | 32'd2, TC);
  endtask

  task automatic testPriority();
    timeNow = TD; rxEvent = 1'b1; rxStatusWr = 1'b1; rxStatusWrData = VBIT;
    cyc(); rxEvent = 0; rxStatusWr = 0; rxStatusWrData = 0;
    checkRx("R5 rearm beats event (valid)", 32'd2, TC);
    timeNow = TD; rxEvent = 1'b1; rxStatusWr = 1'b1; rxStatusWrData = VBIT;
    cyc(); rxEvent = 0; rxStatusWr = 0; rxStatusWrData = 0;
    checkRx("R5 rearm beats event (empty)", 32'd2, TC);
  endtask

  task automatic testDisabled();
    txEnable = 3'd0; cyc(); cyc();
    pulseTx(TD);
    checkTx("R6 disabled no capture", 32'h0, 64'h0);
  endtask

  task automatic testEnableChange();
    txEnable = 3'd5; cyc(); cyc();
    pulseTx(TE);
    checkTx("R2 tx capture", VBIT | 32'd1, TE);
    checkRx("R9 rx untouched by tx", 32'd2, TC);
    txEnable = 3'd3; pulseTx(TF);
    checkTx("R7 enable change clears and drops", 32'd1, TE);
    pulseTx(TF);
    checkTx("R8 capture after reconfig", VBIT | 32'd2, TF);
    checkRx("R9 rx untouched by tx reconfig", 32'd2, TC);
  endtask

  initial begin
    testReset();
    testCapture();
    testHold();
    testRearm();
    testPriority();
    testDisabled();
    testEnableChange();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule